// File: doc/BRIEF.md
# Memory-Operand MAC Coprocessor

This block sits next to one processing element and runs arithmetic instructions whose operands live in main memory. The host element presents a 6-bit opcode and three word addresses, already resolved from its own registers: two sources and one destination. The coprocessor takes only the instructions whose opcode falls in its class. It fetches both source words over a simple request/acknowledge memory port, computes the result, and either writes it back to the destination word or folds it into a private accumulator. The accumulator serves multiply-accumulate sequences such as convolution windows.

Work moves through three stages. Stage 1 holds one issued instruction. Stage 2 decodes it and reads its operands, stalling while a read is outstanding. Stage 3 executes it and, for store-type operations, performs the memory write. A read-accumulator operation presents the running sum for one cycle on a dedicated output and zeroes the accumulator on the following edge. A multiply-accumulate placed right after it therefore starts a fresh sum.

Top module: `mac_copro`

## Requirements
- R1: An opcode whose upper three bits are not 110 is completed on the issue handshake and then ignored: no memory request, no accumulator output, no error pulse, and the accumulator value is unchanged.
- R2: Inside the class, opcode bits [2:0] select the operation: 000 add, 001 subtract, 010 multiply, 011 multiply-accumulate, 100 read-accumulator. Codes 101 to 111 are illegal.
- R3: Add, subtract and multiply write M[dst] = M[srcA] op M[srcB] as 32-bit two's-complement results. Overflow wraps, and the product keeps only its low 32 bits.
- R4: Multiply-accumulate adds the low 32 bits of M[srcA]*M[srcB] into the accumulator and makes no memory write.
- R5: Read-accumulator raises accValid for one cycle with accData equal to the accumulator. The accumulator reads zero from the next cycle on, so a back-to-back read returns 0 and a directly following multiply-accumulate sums from zero.
- R6: An illegal in-class opcode pulses errFlag for one cycle when it reaches stage 3. It otherwise has no effect.
- R7: Memory reads and writes follow program order. A write from an earlier instruction completes before any operand read of a later one, so read-after-write through memory gives the new value.
- R8: A memory request keeps memReq, memWe, memAddr and memWdata unchanged until the cycle in which memAck is high.
- R9: issueReady is low while stage 1 holds an instruction that cannot advance. At most three instructions are in flight.
- R10: After reset, issueReady is high, memReq, accValid and errFlag are low, and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Host presents an instruction |
| issueReady | output | 1 | Coprocessor takes the instruction this cycle |
| issueOpcode | input | 6 | Instruction opcode |
| issueSrcA | input | ADDR_W | Word address of the first source operand |
| issueSrcB | input | ADDR_W | Word address of the second source operand |
| issueDst | input | ADDR_W | Word address of the result |
| memReq | output | 1 | Memory request pending |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Request word address |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Request served this cycle; read data valid |
| memRdata | input | DATA_W | Read data |
| accValid | output | 1 | Accumulator readout strobe |
| accData | output | DATA_W | Accumulator value |
| errFlag | output | 1 | Illegal-opcode pulse |

## Verification
Memory latency is variable, so no result has a fixed arrival cycle. On a zero-wait memory an instruction accepted at edge n reaches stage 3 after its two operand reads and one hand-off cycle. Its write request or accumulator strobe appears from that cycle on. The bench therefore predicts every write and every accumulator readout in program order from a golden memory and accumulator. It compares each one when it appears at the ports, sampling on the falling edge. It checks the one-cycle clear by issuing read-accumulator twice in a row and multiply-accumulate directly after a read.

// File: rtl/mac_copro_pkg.sv
package mac_copro_pkg;

  localparam logic [2:0] COP_CLASS = 3'b110;

  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_SUB   = 3'd1;
  localparam logic [2:0] OP_MUL   = 3'd2;
  localparam logic [2:0] OP_MAC   = 3'd3;
  localparam logic [2:0] OP_RDACC = 3'd4;

  typedef enum logic [1:0] {PH_A, PH_B, PH_DONE} fetch_ph_e;
  typedef enum logic [1:0] {SEL_A, SEL_B, SEL_WR} mem_sel_e;

  typedef struct packed {
    logic     s1Load;
    logic     s2Load;
    logic     s3Load;
    logic     latchA;
    logic     latchB;
    logic     accMac;
    logic     accClear;
    mem_sel_e memSel;
  } strobe_t;

  function automatic logic opFetches(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_MAC);
  endfunction

  function automatic logic opWrites(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

  function automatic logic opLegal(input logic [2:0] op);
    return op <= OP_RDACC;
  endfunction

endpackage

// File: rtl/mac_copro_ctrl.sv
module mac_copro_ctrl
  import mac_copro_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [5:0] issueOpcode,
  output logic       issueReady,
  input  logic       memAck,
  output logic       memReq,
  output logic       memWe,
  output logic [2:0] s2OpOut,
  output logic       accValid,
  output logic       errFlag,
  output strobe_t    st
);

  logic       s1Valid, s2Valid, s3Valid;
  logic [2:0] s1Op, s2Op, s3Op;
  fetch_ph_e  s2Ph;

  logic ownIssue, s3NeedWr, s3Fin, s3Free, s2Fetch, s2ToS3, s1ToS2, rdGrant;

  always_comb begin
    ownIssue   = issueOpcode[5:3] == COP_CLASS;
    s3NeedWr   = s3Valid && opWrites(s3Op);
    s3Fin      = s3Valid && (!s3NeedWr || memAck);
    s3Free     = !s3Valid || s3Fin;
    s2Fetch    = s2Valid && (s2Ph != PH_DONE);
    s2ToS3     = s2Valid && (s2Ph == PH_DONE) && s3Free;
    s1ToS2     = s1Valid && (!s2Valid || s2ToS3);
    issueReady = !s1Valid || s1ToS2;
    memReq     = s3NeedWr || s2Fetch;
    memWe      = s3NeedWr;
    rdGrant    = s2Fetch && !s3NeedWr && memAck;

    st.s1Load   = issueValid && issueReady && ownIssue;
    st.s2Load   = s1ToS2;
    st.s3Load   = s2ToS3;
    st.latchA   = rdGrant && (s2Ph == PH_A);
    st.latchB   = rdGrant && (s2Ph == PH_B);
    st.accMac   = s3Valid && (s3Op == OP_MAC);
    st.accClear = s3Valid && (s3Op == OP_RDACC);
    if (s3NeedWr)          st.memSel = SEL_WR;
    else if (s2Ph == PH_B) st.memSel = SEL_B;
    else                   st.memSel = SEL_A;

    s2OpOut  = s2Op;
    accValid = st.accClear;
    errFlag  = s3Valid && !opLegal(s3Op);
  end

  // stage 1: instruction buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Op    <= '0;
    end else if (st.s1Load) begin
      s1Valid <= 1'b1;
      s1Op    <= issueOpcode[2:0];
    end else if (s1ToS2) begin
      s1Valid <= 1'b0;
    end
  end

  // stage 2: decode and operand fetch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Op    <= '0;
      s2Ph    <= PH_DONE;
    end else if (st.s2Load) begin
      s2Valid <= 1'b1;
      s2Op    <= s1Op;
      s2Ph    <= opFetches(s1Op) ? PH_A : PH_DONE;
    end else if (s2ToS3) begin
      s2Valid <= 1'b0;
    end else if (st.latchA) begin
      s2Ph <= PH_B;
    end else if (st.latchB) begin
      s2Ph <= PH_DONE;
    end
  end

  // stage 3: execute and write back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3Valid <= 1'b0;
      s3Op    <= '0;
    end else if (s2ToS3) begin
      s3Valid <= 1'b1;
      s3Op    <= s2Op;
    end else if (s3Fin) begin
      s3Valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mac_copro_dp.sv
module mac_copro_dp
  import mac_copro_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [2:0]        s2Op,
  input  logic [ADDR_W-1:0] issueSrcA,
  input  logic [ADDR_W-1:0] issueSrcB,
  input  logic [ADDR_W-1:0] issueDst,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] accData
);

  logic [ADDR_W-1:0] s1SrcA, s1SrcB, s1Dst;
  logic [ADDR_W-1:0] s2SrcA, s2SrcB, s2Dst, s3Dst;
  logic [DATA_W-1:0] opA, opB, s3Val, accReg, prodLow, result;

  always_comb begin
    prodLow = opA * opB;
    case (s2Op)
      OP_ADD:         result = opA + opB;
      OP_SUB:         result = opA - opB;
      OP_MUL, OP_MAC: result = prodLow;
      default:        result = '0;
    endcase
    case (st.memSel)
      SEL_WR:  memAddr = s3Dst;
      SEL_B:   memAddr = s2SrcB;
      default: memAddr = s2SrcA;
    endcase
    memWdata = s3Val;
    accData  = accReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1SrcA <= '0; s1SrcB <= '0; s1Dst <= '0;
      s2SrcA <= '0; s2SrcB <= '0; s2Dst <= '0;
      opA    <= '0; opB    <= '0;
      s3Dst  <= '0; s3Val  <= '0;
      accReg <= '0;
    end else begin
      if (st.s1Load) begin
        s1SrcA <= issueSrcA;
        s1SrcB <= issueSrcB;
        s1Dst  <= issueDst;
      end
      if (st.s2Load) begin
        s2SrcA <= s1SrcA;
        s2SrcB <= s1SrcB;
        s2Dst  <= s1Dst;
      end
      if (st.latchA) opA <= memRdata;
      if (st.latchB) opB <= memRdata;
      if (st.s3Load) begin
        s3Dst <= s2Dst;
        s3Val <= result;
      end
      if (st.accClear)    accReg <= '0;
      else if (st.accMac) accReg <= accReg + s3Val;
    end
  end

endmodule

// File: rtl/mac_copro.sv
module mac_copro
  import mac_copro_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [5:0]        issueOpcode,
  input  logic [ADDR_W-1:0] issueSrcA,
  input  logic [ADDR_W-1:0] issueSrcB,
  input  logic [ADDR_W-1:0] issueDst,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              accValid,
  output logic [DATA_W-1:0] accData,
  output logic              errFlag
);

  strobe_t    st;
  logic [2:0] s2Op;

  mac_copro_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOpcode(issueOpcode),
    .issueReady(issueReady), .memAck(memAck), .memReq(memReq), .memWe(memWe),
    .s2OpOut(s2Op), .accValid(accValid), .errFlag(errFlag), .st(st)
  );

  mac_copro_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .s2Op(s2Op), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueDst(issueDst), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .accData(accData)
  );

endmodule

// File: rtl/mac_copro_chk.sv
module mac_copro_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              accValid,
  input logic [DATA_W-1:0] accData,
  input logic              errFlag
);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && (memWe == $past(memWe)));

  // R8
  mem_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));

  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && $past(accValid) |-> accData == '0);

  // R6
  s3_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errFlag, accValid, memReq && memWe}));

  // R9
  issue_bp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueReady |-> memReq);

endmodule

bind mac_copro mac_copro_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .issueReady(issueReady), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .accValid(accValid),
  .accData(accData), .errFlag(errFlag)
);

// File: tb/test_mac_copro.sv
module test_mac_copro;

  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic          issueReady;
  logic [5:0]    issueOpcode = '0;
  logic [AW-1:0] issueSrcA = '0, issueSrcB = '0, issueDst = '0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic          accValid;
  logic [DW-1:0] accData;
  logic          errFlag;

  always #10 clk = ~clk;

  mac_copro #(.DATA_W(DW), .ADDR_W(AW)) i_mac_copro (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueOpcode(issueOpcode), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueDst(issueDst), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .accValid(accValid), .accData(accData), .errFlag(errFlag)
  );

  int checks = 0;
  int fails  = 0;
  int errSeen = 0;
  int expErr = 0;
  logic [DW-1:0] mem  [256];
  logic [DW-1:0] gold [256];
  logic [DW-1:0] goldAcc = '0;
  logic [AW-1:0] expWrAddr [$];
  logic [DW-1:0] expWrData [$];
  logic [DW-1:0] expAcc [$];
  bit memHold = 1'b0;
  bit fastMem = 1'b0;
  int waitCnt = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with random wait states
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq && !memHold) begin
      if (waitCnt == 0 || fastMem) begin
        memAck  = 1'b1;
        waitCnt = $urandom_range(0, 3);
        if (memWe) begin
          if (expWrAddr.size() == 0) begin
            check(1'b0, "R1/R4/R6 unexpected write", {{(DW-AW){1'b0}}, memAddr}, '0);
          end else begin
            logic [AW-1:0] ea;
            logic [DW-1:0] ed;
            ea = expWrAddr.pop_front();
            ed = expWrData.pop_front();
            check(memAddr == ea, "R7 write address", {{(DW-AW){1'b0}}, memAddr},
                  {{(DW-AW){1'b0}}, ea});
            check(memWdata == ed, "R3 write data", memWdata, ed);
          end
          mem[memAddr] = memWdata;
        end else begin
          memRdata = mem[memAddr];
        end
      end else waitCnt--;
    end
  end

  // accumulator readout and error monitor
  always @(negedge clk) begin
    if (rstN && accValid) begin
      if (expAcc.size() == 0) check(1'b0, "R5 unexpected readout", accData, '0);
      else begin
        logic [DW-1:0] ev;
        ev = expAcc.pop_front();
        check(accData == ev, "R4/R5 accumulator", accData, ev);
      end
    end
    if (rstN && errFlag) errSeen++;
  end

  function automatic logic [5:0] opc(input logic [2:0] sub);
    return {3'b110, sub};
  endfunction

  task automatic model(input logic [5:0] op, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, input logic [AW-1:0] d);
    logic [DW-1:0] r;
    if (op[5:3] != 3'b110) return;
    case (op[2:0])
      3'd0, 3'd1, 3'd2: begin
        r = (op[2:0] == 3'd0) ? gold[a] + gold[b] :
            (op[2:0] == 3'd1) ? gold[a] - gold[b] : gold[a] * gold[b];
        gold[d] = r;
        expWrAddr.push_back(d);
        expWrData.push_back(r);
      end
      3'd3: goldAcc = goldAcc + gold[a] * gold[b];
      3'd4: begin expAcc.push_back(goldAcc); goldAcc = '0; end
      default: expErr++;
    endcase
  endtask

  task automatic issue(input logic [5:0] op, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, input logic [AW-1:0] d);
    bit taken = 1'b0;
    model(op, a, b, d);
    @(negedge clk);
    issueValid = 1'b1; issueOpcode = op; issueSrcA = a; issueSrcB = b; issueDst = d;
    while (!taken) begin
      #5;
      if (issueReady) taken = 1'b1;
      else @(negedge clk);
    end
    @(posedge clk);
    #1 issueValid = 1'b0;
  endtask

  task automatic drain();
    while (expWrAddr.size() != 0 || expAcc.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic setWord(input logic [AW-1:0] a, input logic [DW-1:0] v);
    mem[a] = v; gold[a] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) setWord(i[AW-1:0], $urandom());
    repeat (3) @(negedge clk);
    #5;
    // R10 reset state
    check(issueReady && !memReq && !accValid && !errFlag, "R10 reset outputs",
          {28'd0, issueReady, memReq, accValid, errFlag}, 32'h8);
    rstN = 1'b1;

    // R10 accumulator starts at zero; R5 back-to-back read returns 0
    issue(opc(3'd4), 0, 0, 0);
    issue(opc(3'd4), 0, 0, 0);
    drain();

    // R3 wrap and truncation corners
    setWord(1, 32'h7fff_ffff); setWord(2, 32'h0000_0001);
    setWord(3, 32'h8000_0000); setWord(4, 32'hffff_ffff);
    setWord(5, 32'h0001_0003); setWord(6, 32'h0002_0005);
    issue(opc(3'd0), 1, 2, 40);
    issue(opc(3'd1), 3, 2, 41);
    issue(opc(3'd2), 5, 6, 42);
    issue(opc(3'd2), 4, 4, 43);
    // R7 read-after-write through memory
    issue(opc(3'd0), 40, 40, 44);
    drain();

    // R4 R5 MAC, read, MAC directly after read, fast memory
    fastMem = 1'b1;
    issue(opc(3'd3), 5, 6, 0);
    issue(opc(3'd3), 4, 2, 0);
    issue(opc(3'd4), 0, 0, 0);
    issue(opc(3'd3), 1, 2, 0);
    issue(opc(3'd4), 0, 0, 0);
    issue(opc(3'd4), 0, 0, 0);
    drain();
    fastMem = 1'b0;

    // R1 foreign opcode ignored, accumulator untouched
    issue(opc(3'd3), 5, 5, 0);
    drain();
    begin
      bit quiet = 1'b1;
      issue(6'b000110, 7, 8, 9);
      repeat (8) begin
        @(negedge clk);
        if (memReq || accValid || errFlag) quiet = 1'b0;
      end
      check(quiet, "R1 foreign opcode quiet", {31'd0, quiet}, 32'd1);
    end
    issue(opc(3'd4), 0, 0, 0);
    drain();

    // R6 illegal opcode: one error pulse, no effect
    issue(opc(3'd5), 1, 2, 50);
    issue(opc(3'd7), 1, 2, 51);
    drain();
    check(errSeen == expErr, "R6 error pulses", errSeen, expErr);

    // R9 back-pressure with stalled memory
    memHold = 1'b1;
    issue(opc(3'd0), 10, 11, 60);
    issue(opc(3'd1), 12, 13, 61);
    begin
      bit lowAll = 1'b1;
      @(negedge clk);
      issueValid = 1'b1; issueOpcode = opc(3'd2);
      repeat (5) begin
        #5;
        if (issueReady) lowAll = 1'b0;
        @(negedge clk);
      end
      issueValid = 1'b0;
      check(lowAll, "R9 issueReady low when full", {31'd0, !lowAll}, 32'd0);
    end
    memHold = 1'b0;
    issue(opc(3'd2), 60, 61, 62);
    drain();

    // R2 R3 R4 R5 R7 random program
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [5:0] op;
      k = $urandom_range(0, 11);
      case (k)
        0, 1:    op = opc(3'd0);
        2:       op = opc(3'd1);
        3, 4:    op = opc(3'd2);
        5, 6, 7: op = opc(3'd3);
        8, 9:    op = opc(3'd4);
        10:      op = opc(3'($urandom_range(5, 7)));
        default: op = 6'($urandom_range(0, 47));
      endcase
      issue(op, 8'($urandom_range(0, 31)), 8'($urandom_range(0, 31)),
            8'($urandom_range(0, 31)));
    end
    issue(opc(3'd4), 0, 0, 0);
    drain();
    check(errSeen == expErr, "R6 error pulses random", errSeen, expErr);
    check(expWrAddr.size() == 0 && expAcc.size() == 0, "R7 all results seen",
          expWrAddr.size() + expAcc.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule